// File: doc/BRIEF.md
# SPI Target Command Frame Decoder

This block is the command side of a device-side SPI target. The physical shift register is outside it. The block sees the bus as one received byte per slot (`rx_valid`/`rx_byte`) and supplies the byte to send in the next slot on `tx_byte`.

While chip select is low it works through each frame in four steps:
- It decodes the opcode.
- It gathers the address, size and data fields, whose layout depends on the opcode.
- It checks an optional trailing CRC7 byte.
- It then plays out the response: the opcode echoed, a status byte, and for register reads a header byte followed by the read word.

Register accesses leave the block as single-cycle strobes on a simple request port. There are two address spaces: a full 24-bit space and a short 15-bit internal space. DMA command headers are not executed here. They are handed to a separate streaming block as a start pulse carrying the address, the length and the direction.

One internal address is served by the block itself. It is a 7-bit protocol control register, and its bits 3:2 decide whether frames carry a CRC byte. Clearing those bits switches the framing for every later frame.

Top module: `spi_cmd_target`

## Requirements
- R1: After reset `tx_byte` is 0x00 and no strobe (`req_we`, `req_re`, `dma_start`) is raised. At most one strobe is high in any cycle.
- R2: With CRC framing on, one check byte follows the fields. Its bits 7:1 must equal the CRC7 over the opcode and all field bytes, most significant bit first, polynomial x^7+x^3+1 (0x09), register preset 0x7F. Bit 0 of the check byte is ignored.
- R3: Opcode 0xC9 (single write) takes a 3-byte big-endian address and a 4-byte big-endian data word. It raises `req_we` for one cycle with `req_internal`=0 and answers 0xC9, 0x00.
- R4: Opcode 0xCA (single read) takes a 3-byte big-endian address and raises `req_re` for one cycle. `rsp_rdata` is sampled one cycle after `req_re`. The answer is 0xCA, 0x00, 0xF0, then the word least significant byte first, then two 0x00 bytes only when CRC framing is on.
- R5: Opcodes 0xC3 (internal write: 2 address bytes, then 4 big-endian data bytes) and 0xC4 (internal read: 2 address bytes, then 1 pad byte) access the internal space. The 15-bit address is bits 6:0 of the first byte followed by the second byte. Bit 7 of the first byte appears on `req_clockless`, and `req_internal`=1. Responses follow R3 and R4.
- R6: Opcodes 0xC1/0xC2 take a 3-byte address and a 2-byte size. Opcodes 0xC7/0xC8 take a 3-byte address and a 3-byte size. Each raises `dma_start` with the address on `req_addr`, the size on `dma_len`, and `dma_read`=1 for 0xC2/0xC8. No register strobe is raised, and the answer is opcode, 0x00.
- R7: Opcodes 0xC5, 0xC6 and 0xCF carry no fields. They make no access and answer opcode, 0x00.
- R8: A check byte that does not match gives status 0x01. No access is made and the response ends after the status byte.
- R9: An opcode outside the set listed in R3–R7 is answered in the very next slot with the opcode echoed and status 0x01. No field bytes are expected and no access is made.
- R10: Internal address 0x0024 is a local control register with reset value 0x0C. An internal write stores data bits 6:0, and an internal read returns it zero-extended. Neither raises a backend strobe. CRC framing is on exactly when bits 3:2 are nonzero, and a change applies from the next frame.
- R11: Raising `cs_n` abandons a partial frame without any access. The next frame starts from its opcode.
- R12: `tx_byte` is 0x00 while command bytes are being received. After the last response byte, further bytes in the same selection are ignored and `tx_byte` stays 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte to send in the next slot |
| req_addr | output | 24 | Register or DMA address, valid with a strobe |
| req_wdata | output | 32 | Write data, valid with req_we |
| req_we | output | 1 | Register write strobe |
| req_re | output | 1 | Register read strobe |
| req_internal | output | 1 | Strobe targets the internal space |
| req_clockless | output | 1 | Clockless-access flag of an internal access |
| rsp_rdata | input | 32 | Read data, valid one cycle after req_re |
| dma_start | output | 1 | DMA command header accepted |
| dma_read | output | 1 | DMA direction, 1 = read |
| dma_len | output | 24 | DMA transfer size |

## Verification
The hardest situation to reach is a change of framing in the middle of a session. The bench writes the control register to clear the CRC bits. It then sends a frame with no check byte, and the echo must appear straight after the last field byte. A read of the register must return the new value through a response with no trailing CRC bytes. Every unlisted opcode is swept one by one, and frames are cut short by chip select. Check bytes are corrupted both in bit 0, which must still be accepted, and in a CRC bit, which must be rejected with no access.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 24;
  localparam int LEN_W     = 24;
  localparam int DATA_W    = 32;
  localparam int IADDR_W   = 15;
  localparam int CTRL_W    = 7;
  localparam int FLD_BYTES = 7;
  localparam int FLD_W     = FLD_BYTES * BYTE_W;
  localparam int CNT_W     = $clog2(FLD_BYTES + 1);
  localparam int CRC_W     = 7;
  localparam int IDX_W     = 4;

  localparam logic [BYTE_W-1:0] OP_DMA_WR  = 8'hC1;
  localparam logic [BYTE_W-1:0] OP_DMA_RD  = 8'hC2;
  localparam logic [BYTE_W-1:0] OP_INT_WR  = 8'hC3;
  localparam logic [BYTE_W-1:0] OP_INT_RD  = 8'hC4;
  localparam logic [BYTE_W-1:0] OP_TERM    = 8'hC5;
  localparam logic [BYTE_W-1:0] OP_REPEAT  = 8'hC6;
  localparam logic [BYTE_W-1:0] OP_XDMA_WR = 8'hC7;
  localparam logic [BYTE_W-1:0] OP_XDMA_RD = 8'hC8;
  localparam logic [BYTE_W-1:0] OP_SGL_WR  = 8'hC9;
  localparam logic [BYTE_W-1:0] OP_SGL_RD  = 8'hCA;
  localparam logic [BYTE_W-1:0] OP_RESET   = 8'hCF;

  localparam logic [BYTE_W-1:0] STAT_OK  = 8'h00;
  localparam logic [BYTE_W-1:0] STAT_ERR = 8'h01;
  localparam logic [BYTE_W-1:0] RD_HDR   = 8'hF0;

  localparam logic [CRC_W-1:0] CRC_INIT = 7'h7F;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef enum logic [1:0] {P_OP, P_FLD, P_CRC, P_END} pstate_t;

  function automatic logic op_known(input logic [BYTE_W-1:0] op);
    case (op)
      OP_DMA_WR, OP_DMA_RD, OP_INT_WR, OP_INT_RD, OP_TERM, OP_REPEAT,
      OP_XDMA_WR, OP_XDMA_RD, OP_SGL_WR, OP_SGL_RD, OP_RESET: op_known = 1'b1;
      default: op_known = 1'b0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] fld_len(input logic [BYTE_W-1:0] op);
    case (op)
      OP_DMA_WR, OP_DMA_RD:   fld_len = CNT_W'(5);
      OP_INT_WR:              fld_len = CNT_W'(6);
      OP_INT_RD, OP_SGL_RD:   fld_len = CNT_W'(3);
      OP_XDMA_WR, OP_XDMA_RD: fld_len = CNT_W'(6);
      OP_SGL_WR:              fld_len = CNT_W'(7);
      default:                fld_len = CNT_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/spi_cmd_crc7.sv
module spi_cmd_crc7
  import spi_cmd_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  always_comb begin : step_b
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_i;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ data_i[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    crc_o = c;
  end
endmodule

// File: rtl/spi_cmd_parser.sv
module spi_cmd_parser
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              crc_en,
  output logic              done,
  output logic              ok,
  output logic [BYTE_W-1:0] op,
  output logic [FLD_W-1:0]  fld
);
  pstate_t           st_q, st_d;
  logic [BYTE_W-1:0] op_q, op_d;
  logic [FLD_W-1:0]  fld_q, fld_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CRC_W-1:0]  crc_q, crc_d, crc_in, crc_nx;
  logic              done_q, done_d, ok_q, ok_d;

  assign crc_in = (st_q == P_OP) ? CRC_INIT : crc_q;

  spi_cmd_crc7 crc_i (.crc_i(crc_in), .data_i(rx_byte), .crc_o(crc_nx));

  always_comb begin
    st_d = st_q; op_d = op_q; fld_d = fld_q; cnt_d = cnt_q;
    crc_d = crc_q; done_d = 1'b0; ok_d = ok_q;
    if (cs_n) begin
      st_d = P_OP;
    end else if (rx_valid) begin
      case (st_q)
        P_OP: begin
          op_d  = rx_byte;
          crc_d = crc_nx;
          if (!op_known(rx_byte)) begin
            done_d = 1'b1; ok_d = 1'b0; st_d = P_END;
          end else if (fld_len(rx_byte) == '0) begin
            if (crc_en) st_d = P_CRC;
            else begin done_d = 1'b1; ok_d = 1'b1; st_d = P_END; end
          end else begin
            st_d  = P_FLD;
            cnt_d = fld_len(rx_byte) - CNT_W'(1);
          end
        end
        P_FLD: begin
          fld_d = {fld_q[FLD_W-BYTE_W-1:0], rx_byte};
          crc_d = crc_nx;
          if (cnt_q == '0) begin
            if (crc_en) st_d = P_CRC;
            else begin done_d = 1'b1; ok_d = 1'b1; st_d = P_END; end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        P_CRC: begin
          done_d = 1'b1;
          ok_d   = (rx_byte[BYTE_W-1:1] == crc_q);
          st_d   = P_END;
        end
        default: st_d = P_END;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= P_OP; op_q <= '0; fld_q <= '0; cnt_q <= '0;
      crc_q <= CRC_INIT; done_q <= 1'b0; ok_q <= 1'b0;
    end else begin
      st_q <= st_d; op_q <= op_d; fld_q <= fld_d; cnt_q <= cnt_d;
      crc_q <= crc_d; done_q <= done_d; ok_q <= ok_d;
    end
  end

  assign done = done_q;
  assign ok   = ok_q;
  assign op   = op_q;
  assign fld  = fld_q;
endmodule

// File: rtl/spi_cmd_responder.sv
module spi_cmd_responder
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic              start,
  input  logic              ok,
  input  logic              is_read,
  input  logic              crc_en,
  input  logic [BYTE_W-1:0] op,
  input  logic [DATA_W-1:0] rdata,
  output logic [BYTE_W-1:0] tx_byte
);
  logic              act_q, act_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_q, last_d;
  logic [BYTE_W-1:0] op_q, op_d, stat_q, stat_d;

  always_comb begin
    act_d = act_q; idx_d = idx_q; last_d = last_q; op_d = op_q; stat_d = stat_q;
    if (cs_n) begin
      act_d = 1'b0;
    end else if (start) begin
      act_d  = 1'b1;
      idx_d  = '0;
      op_d   = op;
      stat_d = ok ? STAT_OK : STAT_ERR;
      if (ok && is_read) last_d = crc_en ? IDX_W'(8) : IDX_W'(6);
      else               last_d = IDX_W'(1);
    end else if (act_q && rx_valid) begin
      if (idx_q == last_q) act_d = 1'b0;
      else                 idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; idx_q <= '0; last_q <= '0; op_q <= '0; stat_q <= '0;
    end else begin
      act_q <= act_d; idx_q <= idx_d; last_q <= last_d; op_q <= op_d; stat_q <= stat_d;
    end
  end

  always_comb begin
    tx_byte = '0;
    if (act_q) begin
      case (idx_q)
        IDX_W'(0): tx_byte = op_q;
        IDX_W'(1): tx_byte = stat_q;
        IDX_W'(2): tx_byte = RD_HDR;
        IDX_W'(3): tx_byte = rdata[7:0];
        IDX_W'(4): tx_byte = rdata[15:8];
        IDX_W'(5): tx_byte = rdata[23:16];
        IDX_W'(6): tx_byte = rdata[31:24];
        default:   tx_byte = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_target.sv
module spi_cmd_target
  import spi_cmd_pkg::*;
#(
  parameter logic [IADDR_W-1:0] CTRL_ADDR = 15'h0024,
  parameter logic [CTRL_W-1:0]  CTRL_RST  = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              req_we,
  output logic              req_re,
  output logic              req_internal,
  output logic              req_clockless,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              dma_start,
  output logic              dma_read,
  output logic [LEN_W-1:0]  dma_len
);
  logic              done, ok, crc_en, acc;
  logic [BYTE_W-1:0] op;
  logic [FLD_W-1:0]  fld;
  logic              is_sw, is_sr, is_iw, is_ir, is_dma, is_xdma, ctrl_hit;
  logic [BYTE_W-1:0] ia_hi, ia_lo;
  logic [IADDR_W-1:0] iaddr;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_wr, ctrl_rd, rd_pend_q, ctrl_rd_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  spi_cmd_parser parser_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .crc_en(crc_en), .done(done), .ok(ok), .op(op), .fld(fld)
  );

  assign crc_en  = |ctrl_q[3:2];
  assign acc     = done & ok;
  assign is_sw   = (op == OP_SGL_WR);
  assign is_sr   = (op == OP_SGL_RD);
  assign is_iw   = (op == OP_INT_WR);
  assign is_ir   = (op == OP_INT_RD);
  assign is_dma  = (op == OP_DMA_WR) || (op == OP_DMA_RD);
  assign is_xdma = (op == OP_XDMA_WR) || (op == OP_XDMA_RD);

  // Internal address bytes sit at different depths of the field shifter.
  assign ia_hi    = is_iw ? fld[47:40] : fld[23:16];
  assign ia_lo    = is_iw ? fld[39:32] : fld[15:8];
  assign iaddr    = {ia_hi[6:0], ia_lo};
  assign ctrl_hit = (iaddr == CTRL_ADDR);

  assign req_we        = acc & (is_sw | (is_iw & ~ctrl_hit));
  assign req_re        = acc & (is_sr | (is_ir & ~ctrl_hit));
  assign dma_start     = acc & (is_dma | is_xdma);
  assign req_internal  = done & (is_iw | is_ir);
  assign req_clockless = done & (is_iw | is_ir) & ia_hi[7];
  assign req_wdata     = fld[DATA_W-1:0];
  assign dma_read      = (op == OP_DMA_RD) || (op == OP_XDMA_RD);
  assign dma_len       = is_xdma ? fld[23:0] : {8'h00, fld[15:0]};

  always_comb begin
    if (is_iw || is_ir)  req_addr = {{(ADDR_W-IADDR_W){1'b0}}, iaddr};
    else if (is_sw)      req_addr = fld[55:32];
    else if (is_xdma)    req_addr = fld[47:24];
    else if (is_dma)     req_addr = fld[39:16];
    else                 req_addr = fld[23:0];
  end

  assign ctrl_wr = acc & is_iw & ctrl_hit;
  assign ctrl_rd = acc & is_ir & ctrl_hit;
  assign ctrl_d  = ctrl_wr ? fld[CTRL_W-1:0] : ctrl_q;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_pend_q)      rdata_d = rsp_rdata;
    else if (ctrl_rd_q) rdata_d = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST; rd_pend_q <= 1'b0; ctrl_rd_q <= 1'b0; rdata_q <= '0;
    end else begin
      ctrl_q <= ctrl_d; rd_pend_q <= req_re; ctrl_rd_q <= ctrl_rd; rdata_q <= rdata_d;
    end
  end

  spi_cmd_responder resp_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .start(done),
    .ok(ok), .is_read(is_sr | is_ir), .crc_en(crc_en), .op(op), .rdata(rdata_q),
    .tx_byte(tx_byte)
  );
endmodule

// File: rtl/spi_cmd_target_chk.sv
module spi_cmd_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [7:0] tx_byte,
  input logic       req_we,
  input logic       req_re,
  input logic       dma_start,
  input logic       req_internal,
  input logic       req_clockless
);
  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_we, req_re, dma_start}));
  // R3
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_we |=> !req_we);
  // R4
  re_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_re |=> !req_re);
  // R5
  clockless_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_clockless |-> req_internal);
  // R11
  cs_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !(req_we || req_re || dma_start));
  // R12
  cs_idle_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (tx_byte == 8'h00));
endmodule

bind spi_cmd_target spi_cmd_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .tx_byte(tx_byte), .req_we(req_we),
  .req_re(req_re), .dma_start(dma_start), .req_internal(req_internal),
  .req_clockless(req_clockless)
);

// File: tb/spi_cmd_target_tb_top.sv
module spi_cmd_target_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, cs_n, rx_valid;
  logic [7:0]  rx_byte, tx_byte;
  logic [23:0] req_addr, dma_len;
  logic [31:0] req_wdata, rsp_rdata;
  logic        req_we, req_re, req_internal, req_clockless, dma_start, dma_read;

  spi_cmd_target dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we),
    .req_re(req_re), .req_internal(req_internal), .req_clockless(req_clockless),
    .rsp_rdata(rsp_rdata), .dma_start(dma_start), .dma_read(dma_read), .dma_len(dma_len)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  int n_we = 0, n_re = 0, n_dma = 0;
  logic [23:0] l_addr, l_dlen;
  logic [31:0] l_wdata;
  logic        l_int, l_cl, l_drd;
  logic [7:0]  cb [16];
  logic [7:0]  rb [16];
  int          cn;

  function automatic logic [31:0] rmodel(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a[23:16], a[15:8] ^ 8'h3C, a[7:0] + 8'h11};
  endfunction

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic [7:0] b);
    logic [6:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[6] ^ b[i]) r = {r[5:0], 1'b0} ^ 7'h09;
      else             r = {r[5:0], 1'b0};
    end
    return r;
  endfunction

  function automatic bit known(input logic [7:0] o);
    return (o >= 8'hC1 && o <= 8'hCA) || o == 8'hCF;
  endfunction

  // Backend model and strobe monitor.
  always @(posedge clk) begin
    if (req_re) rsp_rdata <= rmodel(req_addr);
    if (rst_n) begin
      if (req_we) begin
        n_we <= n_we + 1; l_addr <= req_addr; l_wdata <= req_wdata;
        l_int <= req_internal; l_cl <= req_clockless;
      end
      if (req_re) begin
        n_re <= n_re + 1; l_addr <= req_addr; l_int <= req_internal; l_cl <= req_clockless;
      end
      if (dma_start) begin
        n_dma <= n_dma + 1; l_addr <= req_addr; l_dlen <= dma_len; l_drd <= dma_read;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    @(negedge clk);
    r = tx_byte;
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int nresp, input bit add_crc, input logic [7:0] crc_x);
    logic [7:0] r;
    logic [6:0] c;
    bit bad;
    bad = 0;
    c = 7'h7F;
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < cn; i++) begin
      c = crc_step(c, cb[i]);
      xfer(cb[i], r);
      if (r !== 8'h00) bad = 1;
    end
    if (add_crc) begin
      xfer({c, 1'b0} ^ crc_x, r);
      if (r !== 8'h00) bad = 1;
    end
    for (int i = 0; i <= nresp; i++) xfer(8'h00, rb[i]);
    chk("R12 tx during command bytes", 32'(bad), 0);
    chk("R12 tx after response", 32'(rb[nresp]), 0);
    @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_rd(input string tag, input logic [31:0] d, input bit crc_on);
    chk({tag, " header"}, 32'(rb[2]), 32'hF0);
    chk({tag, " data b0"}, 32'(rb[3]), 32'(d[7:0]));
    chk({tag, " data b1"}, 32'(rb[4]), 32'(d[15:8]));
    chk({tag, " data b2"}, 32'(rb[5]), 32'(d[23:16]));
    chk({tag, " data b3"}, 32'(rb[6]), 32'(d[31:24]));
    if (crc_on) begin
      chk({tag, " crc pad0"}, 32'(rb[7]), 0);
      chk({tag, " crc pad1"}, 32'(rb[8]), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog expired actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail);
    $finish;
  end

  initial begin
    int w0, r0, d0;
    logic [7:0] r;
    rst_n = 1'b0; cs_n = 1'b1; rx_valid = 1'b0; rx_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset tx", 32'(tx_byte), 0);
    chk("R1 reset strobes", 32'(n_we + n_re + n_dma), 0);

    // R3 single writes, CRC on
    for (int i = 0; i < 6; i++) begin
      logic [23:0] a; logic [31:0] d;
      a = 24'(i * 24'h13579B + 24'h0A0B0C);
      d = 32'(i * 32'h9E3779B1) ^ 32'h12345678;
      cb[0] = 8'hC9; cb[1] = a[23:16]; cb[2] = a[15:8]; cb[3] = a[7:0];
      cb[4] = d[31:24]; cb[5] = d[23:16]; cb[6] = d[15:8]; cb[7] = d[7:0]; cn = 8;
      w0 = n_we;
      run(2, 1, 8'h00);
      chk("R3 echo", 32'(rb[0]), 32'hC9);
      chk("R3 status", 32'(rb[1]), 0);
      chk("R3 write count", 32'(n_we), 32'(w0 + 1));
      chk("R3 address", 32'(l_addr), 32'(a));
      chk("R3 data", l_wdata, d);
      chk("R3 not internal", 32'(l_int), 0);
    end

    // R4 single reads, CRC on
    for (int i = 0; i < 6; i++) begin
      logic [23:0] a;
      a = 24'(i * 24'h2468AD + 24'h00F00D);
      cb[0] = 8'hCA; cb[1] = a[23:16]; cb[2] = a[15:8]; cb[3] = a[7:0]; cn = 4;
      r0 = n_re;
      run(9, 1, 8'h00);
      chk("R4 echo", 32'(rb[0]), 32'hCA);
      chk("R4 status", 32'(rb[1]), 0);
      chk_rd("R4", rmodel(a), 1);
      chk("R4 read count", 32'(n_re), 32'(r0 + 1));
      chk("R4 address", 32'(l_addr), 32'(a));
    end

    // R5 internal write and read, both clockless settings
    for (int cl = 0; cl < 2; cl++) begin
      logic [14:0] ia; logic [31:0] d;
      ia = 15'h1A2B + 15'(cl * 15'h0111);
      d  = 32'hCAFE0000 + 32'(cl);
      cb[0] = 8'hC3; cb[1] = {cl[0], ia[14:8]}; cb[2] = ia[7:0];
      cb[3] = d[31:24]; cb[4] = d[23:16]; cb[5] = d[15:8]; cb[6] = d[7:0]; cn = 7;
      w0 = n_we;
      run(2, 1, 8'h00);
      chk("R5 iw echo", 32'(rb[0]), 32'hC3);
      chk("R5 iw status", 32'(rb[1]), 0);
      chk("R5 iw count", 32'(n_we), 32'(w0 + 1));
      chk("R5 iw address", 32'(l_addr), 32'(ia));
      chk("R5 iw data", l_wdata, d);
      chk("R5 iw internal", 32'(l_int), 1);
      chk("R5 iw clockless", 32'(l_cl), 32'(cl));
      cb[0] = 8'hC4; cb[3] = 8'h00; cn = 4;
      r0 = n_re;
      run(9, 1, 8'h00);
      chk("R5 ir echo", 32'(rb[0]), 32'hC4);
      chk("R5 ir status", 32'(rb[1]), 0);
      chk_rd("R5 ir", rmodel({9'h000, ia}), 1);
      chk("R5 ir count", 32'(n_re), 32'(r0 + 1));
      chk("R5 ir address", 32'(l_addr), 32'(ia));
      chk("R5 ir internal", 32'(l_int), 1);
      chk("R5 ir clockless", 32'(l_cl), 32'(cl));
    end

    // R6 DMA headers
    for (int k = 0; k < 4; k++) begin
      logic [7:0] o; logic [23:0] a, sz; bit ext;
      o = (k == 0) ? 8'hC1 : (k == 1) ? 8'hC2 : (k == 2) ? 8'hC7 : 8'hC8;
      ext = (k >= 2);
      a  = 24'h30A050 + 24'(k * 24'h010203);
      sz = ext ? 24'h0A0B0C + 24'(k) : 24'h000123 + 24'(k * 24'h0101);
      cb[0] = o; cb[1] = a[23:16]; cb[2] = a[15:8]; cb[3] = a[7:0];
      if (ext) begin cb[4] = sz[23:16]; cb[5] = sz[15:8]; cb[6] = sz[7:0]; cn = 7; end
      else     begin cb[4] = sz[15:8]; cb[5] = sz[7:0]; cn = 6; end
      w0 = n_we; r0 = n_re; d0 = n_dma;
      run(2, 1, 8'h00);
      chk("R6 echo", 32'(rb[0]), 32'(o));
      chk("R6 status", 32'(rb[1]), 0);
      chk("R6 dma count", 32'(n_dma), 32'(d0 + 1));
      chk("R6 address", 32'(l_addr), 32'(a));
      chk("R6 length", 32'(l_dlen), 32'(sz));
      chk("R6 direction", 32'(l_drd), 32'(k == 1 || k == 3));
      chk("R6 no register strobe", 32'(n_we + n_re), 32'(w0 + r0));
    end

    // R7 field-less opcodes
    for (int k = 0; k < 3; k++) begin
      logic [7:0] o;
      o = (k == 0) ? 8'hC5 : (k == 1) ? 8'hC6 : 8'hCF;
      cb[0] = o; cn = 1;
      w0 = n_we + n_re + n_dma;
      run(2, 1, 8'h00);
      chk("R7 echo", 32'(rb[0]), 32'(o));
      chk("R7 status", 32'(rb[1]), 0);
      chk("R7 no access", 32'(n_we + n_re + n_dma), 32'(w0));
    end

    // R8 corrupted CRC bit; R2 bit 0 of the check byte ignored
    cb[0] = 8'hC9; cb[1] = 8'h12; cb[2] = 8'h34; cb[3] = 8'h56;
    cb[4] = 8'hDE; cb[5] = 8'hAD; cb[6] = 8'hBE; cb[7] = 8'hEF; cn = 8;
    w0 = n_we;
    run(2, 1, 8'h02);
    chk("R8 echo", 32'(rb[0]), 32'hC9);
    chk("R8 status", 32'(rb[1]), 1);
    chk("R8 no write", 32'(n_we), 32'(w0));
    run(2, 1, 8'h01);
    chk("R2 bit0 ignored status", 32'(rb[1]), 0);
    chk("R2 bit0 ignored write", 32'(n_we), 32'(w0 + 1));
    cb[0] = 8'hCA; cn = 4;
    r0 = n_re;
    run(2, 1, 8'h80);
    chk("R8 read status", 32'(rb[1]), 1);
    chk("R8 no read", 32'(n_re), 32'(r0));

    // R9 sweep of every unlisted opcode
    w0 = n_we + n_re + n_dma;
    for (int o = 0; o < 256; o++) begin
      if (!known(8'(o))) begin
        cb[0] = 8'(o); cn = 1;
        run(2, 0, 8'h00);
        chk("R9 echo", 32'(rb[0]), 32'(o));
        chk("R9 status", 32'(rb[1]), 1);
      end
    end
    chk("R9 no access", 32'(n_we + n_re + n_dma), 32'(w0));

    // R11 frame cut by chip select
    w0 = n_we;
    @(negedge clk);
    cs_n = 1'b0;
    xfer(8'hC9, r); xfer(8'h01, r); xfer(8'h02, r); xfer(8'h03, r);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 abandoned frame no write", 32'(n_we), 32'(w0));
    chk("R11 tx idle", 32'(tx_byte), 0);
    cb[0] = 8'hC9; cb[1] = 8'h00; cb[2] = 8'h00; cb[3] = 8'h10;
    cb[4] = 8'h01; cb[5] = 8'h02; cb[6] = 8'h03; cb[7] = 8'h04; cn = 8;
    run(2, 1, 8'h00);
    chk("R11 next frame status", 32'(rb[1]), 0);
    chk("R11 next frame data", l_wdata, 32'h01020304);

    // R10 control register
    cb[0] = 8'hC4; cb[1] = 8'h00; cb[2] = 8'h24; cb[3] = 8'h00; cn = 4;
    r0 = n_re;
    run(9, 1, 8'h00);
    chk("R10 ctrl read status", 32'(rb[1]), 0);
    chk_rd("R10 ctrl reset value", 32'h0000000C, 1);
    chk("R10 ctrl read no strobe", 32'(n_re), 32'(r0));
    cb[0] = 8'hC3; cb[1] = 8'h00; cb[2] = 8'h24;
    cb[3] = 8'h00; cb[4] = 8'h00; cb[5] = 8'h00; cb[6] = 8'h50; cn = 7;
    w0 = n_we;
    run(2, 1, 8'h00);
    chk("R10 ctrl write status", 32'(rb[1]), 0);
    chk("R10 ctrl write no strobe", 32'(n_we), 32'(w0));
    cb[0] = 8'hC9; cb[1] = 8'h44; cb[2] = 8'h55; cb[3] = 8'h66;
    cb[4] = 8'hA1; cb[5] = 8'hB2; cb[6] = 8'hC3; cb[7] = 8'hD4; cn = 8;
    run(2, 0, 8'h00);
    chk("R10 no-crc frame echo", 32'(rb[0]), 32'hC9);
    chk("R10 no-crc frame status", 32'(rb[1]), 0);
    chk("R10 no-crc frame write", 32'(n_we), 32'(w0 + 1));
    cb[0] = 8'hC4; cb[1] = 8'h80; cb[2] = 8'h24; cb[3] = 8'h00; cn = 4;
    run(7, 0, 8'h00);
    chk("R10 ctrl readback echo", 32'(rb[0]), 32'hC4);
    chk_rd("R10 ctrl readback", 32'h00000050, 0);
    cb[0] = 8'hC3; cb[1] = 8'h00; cb[2] = 8'h24;
    cb[3] = 8'h00; cb[4] = 8'h00; cb[5] = 8'h00; cb[6] = 8'h0C; cn = 7;
    run(2, 0, 8'h00);
    cb[0] = 8'hCA; cb[1] = 8'h01; cb[2] = 8'h02; cb[3] = 8'h03; cn = 4;
    run(9, 1, 8'h00);
    chk("R10 crc restored status", 32'(rb[1]), 0);
    chk_rd("R10 crc restored", rmodel(24'h010203), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule